// File: doc/BRIEF.md
# Task Context Save/Restore Sequencer

This block carries out the memory half of a hardware task switch. When the processor has decided to switch tasks, it pulses `start` with two record base addresses: the outgoing task's record and the incoming task's record. Each record is a 104-byte image laid out as 26 consecutive 32-bit words. The block captures the outgoing register context at that moment. It writes the changing part of that context into the outgoing record. It then reads every word of the incoming record and presents the decoded fields on a wide parallel bus.

Memory is reached through a single request/acknowledge port with byte addresses and 32-bit data. Every access holds its address and data until it is acknowledged, so a memory of any latency can sit behind the port. The fields that never change during a task's life are only ever read: the three privileged stack pointers, the page-directory base, the local-table selector and the trap/map word. When the load finishes, `done` pulses for one cycle. If the incoming record asks for a debug trap, `trap_req` pulses with it.

Top module: `task_ctx_seq`

## Requirements
- R1: While reset is held and right after it, `busy`, `done`, `mem_req` and `trap_req` are all low.
- R2: The save phase issues exactly 16 writes to byte addresses old_base+32, +36, ... +92, in ascending order. Word 8 takes the instruction pointer and word 9 the flags image. Words 10..17 take general registers 0..7. Words 18..23 take selectors 0..5 in bits 15:0, with bits 31:16 written as zero.
- R3: Every save write is acknowledged before the first read is issued. The load phase then issues exactly 26 reads at new_base+0, +4, ... +100, in ascending order.
- R4: Words 0..7, 24 and 25 of the outgoing record are never written.
- R5: When `done` is high, the outputs hold the incoming record, and they stay unchanged until the next accepted start. Word 0 bits 15:0 give `nx_link`. Words 1/3/5 give `nx_sp[0..2]`, and words 2/4/6 bits 15:0 give `nx_ss[0..2]`. Word 7 gives `nx_pdbr`, 8 gives `nx_ip`, 9 gives `nx_flags`. Words 10..17 give `nx_gpr[0..7]`, and words 18..23 bits 15:0 give `nx_sel[0..5]`. Word 24 bits 15:0 give `nx_ldt`.
- R6: Word 25 bit 0 drives `nx_trap` and word 25 bits 31:16 drive `nx_iomap`. `trap_req` is high exactly in the `done` cycle of a load whose bit 0 was 1.
- R7: While a request waits for acknowledge, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay constant. The address advances only after an acknowledge.
- R8: `busy` is high from the cycle after an accepted start until the last acknowledge. `done` is a single-cycle pulse in the cycle where `busy` has just fallen.
- R9: A `start` pulse while `busy` is high is ignored. The run in progress keeps its bases and access count, and no second run follows.
- R10: The values written in the save phase are those on the context inputs in the cycle `start` was accepted. Later changes to those inputs have no effect, and the flags image is stored exactly as supplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a switch (taken only when idle) |
| old_base | input | AW | Byte base of outgoing record |
| new_base | input | AW | Byte base of incoming record |
| cur_gpr | input | 8x32 | Outgoing general registers, index 0..7 |
| cur_sel | input | 6x16 | Outgoing segment selectors, index 0..5 |
| cur_flags | input | 32 | Flags image to save (caller-prepared) |
| cur_ip | input | 32 | Instruction pointer to save |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with ack |
| mem_ack | input | 1 | Access completes this cycle |
| busy | output | 1 | Switch in progress |
| done | output | 1 | One-cycle completion pulse |
| trap_req | output | 1 | Debug trap requested by incoming record |
| nx_link | output | 16 | Previous-task link |
| nx_sp | output | 3x32 | Privileged stack offsets, levels 0..2 |
| nx_ss | output | 3x16 | Privileged stack selectors, levels 0..2 |
| nx_pdbr | output | 32 | Page-directory base |
| nx_ip | output | 32 | Instruction pointer |
| nx_flags | output | 32 | Flags |
| nx_gpr | output | 8x32 | General registers |
| nx_sel | output | 6x16 | Segment selectors |
| nx_ldt | output | 16 | Local-table selector |
| nx_trap | output | 1 | Debug-trap bit |
| nx_iomap | output | 16 | I/O map offset |

## Verification
The assertions assume that `mem_ack` is only raised for one cycle in answer to a pending `mem_req`. They also assume that both bases are word aligned and that the two records do not overlap. The bench's memory model acknowledges only outstanding requests, after a programmable wait of zero to a few cycles, and it drops its acknowledge after one cycle. The bench places the two records at disjoint aligned bases and swaps them between runs. It also pokes `start` mid-run and changes the context inputs after the start pulse, all within these assumptions.

// File: rtl/task_ctx_seq.sv
module task_ctx_seq #(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [AW-1:0]        old_base,
  input  logic [AW-1:0]        new_base,
  input  logic [7:0][31:0]     cur_gpr,
  input  logic [5:0][15:0]     cur_sel,
  input  logic [31:0]          cur_flags,
  input  logic [31:0]          cur_ip,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [31:0]          mem_wdata,
  input  logic [31:0]          mem_rdata,
  input  logic                 mem_ack,
  output logic                 busy,
  output logic                 done,
  output logic                 trap_req,
  output logic [15:0]          nx_link,
  output logic [2:0][31:0]     nx_sp,
  output logic [2:0][15:0]     nx_ss,
  output logic [31:0]          nx_pdbr,
  output logic [31:0]          nx_ip,
  output logic [31:0]          nx_flags,
  output logic [7:0][31:0]     nx_gpr,
  output logic [5:0][15:0]     nx_sel,
  output logic [15:0]          nx_ldt,
  output logic                 nx_trap,
  output logic [15:0]          nx_iomap
);

  localparam logic [4:0] SV_FIRST = 5'd8;
  localparam logic [4:0] SV_LAST  = 5'd23;
  localparam logic [4:0] LD_LAST  = 5'd25;
  localparam logic [4:0] GPR_W0   = 5'd10;
  localparam logic [4:0] SEL_W0   = 5'd18;

  typedef enum logic [1:0] {ST_IDLE, ST_SAVE, ST_LOAD} st_t;

  st_t             st;
  logic [4:0]      idx;
  logic [AW-1:0]   old_q, new_q;
  logic [7:0][31:0] gpr_q;
  logic [5:0][15:0] sel_q;
  logic [31:0]     flags_q, ip_q;

  logic [4:0] gi, si, pi;
  assign gi = idx - GPR_W0;
  assign si = idx - SEL_W0;
  assign pi = idx - 5'd1;

  assign busy     = (st != ST_IDLE);
  assign mem_req  = busy;
  assign mem_we   = (st == ST_SAVE);
  assign mem_addr = (st == ST_LOAD ? new_q : old_q) + AW'({idx, 2'b00});
  assign trap_req = done & nx_trap;

  always_comb begin
    mem_wdata = 32'd0;
    if (st == ST_SAVE) begin
      if (idx == SV_FIRST)            mem_wdata = ip_q;
      else if (idx == SV_FIRST + 5'd1) mem_wdata = flags_q;
      else if (idx < SEL_W0)          mem_wdata = gpr_q[gi[2:0]];
      else                            mem_wdata = {16'd0, sel_q[si[2:0]]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      idx <= '0;
      done <= 1'b0;
      old_q <= '0;
      new_q <= '0;
      gpr_q <= '0;
      sel_q <= '0;
      flags_q <= '0;
      ip_q <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st <= ST_SAVE;
          idx <= SV_FIRST;
          old_q <= old_base;
          new_q <= new_base;
          gpr_q <= cur_gpr;
          sel_q <= cur_sel;
          flags_q <= cur_flags;
          ip_q <= cur_ip;
        end
        ST_SAVE: if (mem_ack) begin
          if (idx == SV_LAST) begin
            st <= ST_LOAD;
            idx <= '0;
          end else idx <= idx + 5'd1;
        end
        ST_LOAD: if (mem_ack) begin
          if (idx == LD_LAST) begin
            st <= ST_IDLE;
            idx <= '0;
            done <= 1'b1;
          end else idx <= idx + 5'd1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nx_link <= '0;
      nx_sp <= '0;
      nx_ss <= '0;
      nx_pdbr <= '0;
      nx_ip <= '0;
      nx_flags <= '0;
      nx_gpr <= '0;
      nx_sel <= '0;
      nx_ldt <= '0;
      nx_trap <= 1'b0;
      nx_iomap <= '0;
    end else if (st == ST_LOAD && mem_ack) begin
      if (idx == 5'd0)              nx_link <= mem_rdata[15:0];
      else if (idx <= 5'd6) begin
        if (idx[0])                 nx_sp[pi[2:1]] <= mem_rdata;
        else                        nx_ss[pi[2:1]] <= mem_rdata[15:0];
      end
      else if (idx == 5'd7)         nx_pdbr <= mem_rdata;
      else if (idx == 5'd8)         nx_ip <= mem_rdata;
      else if (idx == 5'd9)         nx_flags <= mem_rdata;
      else if (idx < SEL_W0)        nx_gpr[gi[2:0]] <= mem_rdata;
      else if (idx <= SV_LAST)      nx_sel[si[2:0]] <= mem_rdata[15:0];
      else if (idx == 5'd24)        nx_ldt <= mem_rdata[15:0];
      else begin
        nx_trap <= mem_rdata[0];
        nx_iomap <= mem_rdata[31:16];
      end
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R2
  save_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> ((mem_addr - old_q) >= AW'(32)) && ((mem_addr - old_q) <= AW'(92)));

  // R3
  no_write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |=> !(mem_req && mem_we));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !(mem_we && idx == SV_LAST) && !(!mem_we && idx == LD_LAST)
    |=> mem_req && mem_addr == $past(mem_addr) + AW'(4));

  // R8
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);

  // R6
  trap_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> done);

endmodule

// File: tb/task_ctx_seq_tb.sv
module task_ctx_seq_tb;
  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] old_base = 0, new_base = 0;
  logic [7:0][31:0] cur_gpr = '0;
  logic [5:0][15:0] cur_sel = '0;
  logic [31:0] cur_flags = 0, cur_ip = 0;
  logic mem_req, mem_we, mem_ack, busy, done, trap_req;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [15:0] nx_link, nx_ldt, nx_iomap;
  logic [2:0][31:0] nx_sp;
  logic [2:0][15:0] nx_ss;
  logic [31:0] nx_pdbr, nx_ip, nx_flags;
  logic [7:0][31:0] nx_gpr;
  logic [5:0][15:0] nx_sel;
  logic nx_trap;

  always #10 clk = ~clk;

  task_ctx_seq u_dut (.*);

  logic [31:0] mem [0:63];
  logic        fill_en = 0;
  logic [5:0]  fill_idx = 0;
  logic [31:0] fill_dat = 0;
  int          lat = 0;
  int          wcnt;
  logic        ack_q;
  logic [31:0] log_a [0:255];
  logic        log_w [0:255];
  int          n_acc = 0;

  assign mem_ack   = ack_q;
  assign mem_rdata = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    if (!rst_n) begin ack_q <= 0; wcnt <= 0; end
    else if (!mem_req || ack_q) begin ack_q <= 0; wcnt <= 0; end
    else if (wcnt >= lat) ack_q <= 1;
    else wcnt <= wcnt + 1;
    if (fill_en) mem[fill_idx] <= fill_dat;
    else if (mem_req && ack_q && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    if (mem_req && ack_q) begin
      log_a[n_acc] <= mem_addr; log_w[n_acc] <= mem_we; n_acc <= n_acc + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  logic [7:0][31:0] sv_gpr;
  logic [5:0][15:0] sv_sel;
  logic [31:0] sv_flags, sv_ip;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] seed, input int i, input bit trap);
    if (i == 25) return {seed[15:0] ^ 16'h0068, 15'd0, trap};
    return seed + 32'(i) * 32'h01030507;
  endfunction

  task automatic fill_rec(input logic [31:0] base, input logic [31:0] seed, input bit trap);
    for (int i = 0; i < 26; i++) begin
      @(negedge clk);
      fill_en = 1; fill_idx = 6'(base[7:2] + 6'(i)); fill_dat = pat(seed, i, trap);
    end
    @(negedge clk) fill_en = 0;
  endtask

  function automatic logic [31:0] exp_save(input int w);
    if (w == 8) return sv_ip;
    if (w == 9) return sv_flags;
    if (w < 18) return sv_gpr[w-10];
    return {16'd0, sv_sel[w-18]};
  endfunction

  function automatic logic [31:0] got_word(input int w);
    if (w == 0) return {16'd0, nx_link};
    if (w <= 6) return (w % 2) ? nx_sp[(w-1)/2] : {16'd0, nx_ss[(w-1)/2]};
    if (w == 7) return nx_pdbr;
    if (w == 8) return nx_ip;
    if (w == 9) return nx_flags;
    if (w < 18) return nx_gpr[w-10];
    if (w < 24) return {16'd0, nx_sel[w-18]};
    if (w == 24) return {16'd0, nx_ldt};
    return {nx_iomap, 15'd0, nx_trap};
  endfunction

  function automatic logic [31:0] want_word(input logic [31:0] seed, input int w, input bit trap);
    logic [31:0] v = pat(seed, w, trap);
    if (w == 0 || w == 2 || w == 4 || w == 6 || (w >= 18 && w <= 24)) v[31:16] = 16'd0;
    return v;
  endfunction

  task automatic set_ctx(input logic [31:0] s);
    for (int i = 0; i < 8; i++) cur_gpr[i] = s ^ (32'h11111111 * 32'(i + 1));
    for (int i = 0; i < 6; i++) cur_sel[i] = s[15:0] + 16'(i * 8 + 3);
    cur_flags = s ^ 32'h0000_4202;
    cur_ip = s + 32'h100;
  endtask

  task automatic run_switch(input string nm, input logic [31:0] ob, input logic [31:0] nb,
                            input int l, input bit trap, input bit poke, input bit mutate);
    int base_n, bad, lowc, cyc;
    logic [31:0] os, ns;
    os = 32'hA000_0000 ^ ob; ns = 32'h5000_0000 ^ nb ^ 32'(l);
    fill_rec(ob, os, 1'b0);
    fill_rec(nb, ns, trap);
    lat = l;
    set_ctx(32'hC0DE_0000 + 32'(l) * 32'h77);
    sv_gpr = cur_gpr; sv_sel = cur_sel; sv_flags = cur_flags; sv_ip = cur_ip;
    base_n = n_acc;
    @(negedge clk); old_base = ob; new_base = nb; start = 1;
    @(negedge clk); start = 0;
    lowc = 0; cyc = 0;
    while (!done && cyc < 2000) begin
      if (!busy) lowc++;
      if (mutate && cyc == 1) set_ctx(32'hDEAD_BEEF);
      if (poke && cyc == 10) begin start = 1; old_base = nb; new_base = ob; end
      else start = 0;
      @(negedge clk); cyc++;
    end
    start = 0;
    // R8: busy held through the run, done reached
    chk(done && lowc == 0, {"R8 busy/done ", nm}, {31'd0, done}, 32'd1);
    // R6
    chk(trap_req == trap && nx_trap == trap, {"R6 trap_req ", nm}, {31'd0, trap_req}, {31'd0, trap});
    chk(nx_iomap == (ns[15:0] ^ 16'h0068), {"R6 iomap ", nm}, {16'd0, nx_iomap}, {16'd0, ns[15:0] ^ 16'h0068});
    // R2 R3 access order
    bad = 0;
    for (int k = 0; k < n_acc - base_n; k++) begin
      if (k < 16) begin if (!log_w[base_n+k] || log_a[base_n+k] != ob + 32 + 32'(4*k)) bad++; end
      else if (log_w[base_n+k] || log_a[base_n+k] != nb + 32'(4*(k-16))) bad++;
    end
    chk(n_acc - base_n == 42 && bad == 0, {"R2 R3 R9 access sequence ", nm}, 32'(n_acc - base_n), 32'd42);
    // R2 R10 saved contents
    bad = 0;
    for (int w = 8; w < 24; w++) if (mem[ob[7:2] + 6'(w)] != exp_save(w)) bad++;
    chk(bad == 0, {"R2 R10 saved words ", nm}, 32'(bad), 32'd0);
    // R4 static words untouched
    bad = 0;
    for (int w = 0; w < 26; w++)
      if ((w < 8 || w > 23) && mem[ob[7:2] + 6'(w)] != pat(os, w, 1'b0)) bad++;
    chk(bad == 0, {"R4 static words ", nm}, 32'(bad), 32'd0);
    // R5 loaded fields
    bad = 0;
    for (int w = 0; w < 26; w++) if (got_word(w) != want_word(ns, w, trap)) bad++;
    chk(bad == 0, {"R5 loaded fields ", nm}, 32'(bad), 32'd0);
    @(negedge clk);
    // R8 single pulse
    chk(!done && !trap_req && !busy, {"R8 pulse end ", nm}, {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !mem_req && !done && !trap_req, "R1 in reset", {28'd0, busy, mem_req, done, trap_req}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !mem_req && !done && !trap_req, "R1 after reset", {28'd0, busy, mem_req, done, trap_req}, 32'd0);

    run_switch("basic", 32'h00, 32'h80, 0, 1'b0, 1'b0, 1'b0);
    run_switch("slow trap mutate", 32'h80, 32'h00, 3, 1'b1, 1'b0, 1'b1);
    run_switch("poke", 32'h00, 32'h80, 1, 1'b0, 1'b1, 1'b0);

    // R9 no second run after the poked start; R5 outputs held
    begin
      logic [31:0] ip0;
      int n0;
      ip0 = nx_ip; n0 = n_acc;
      repeat (20) @(negedge clk);
      chk(!busy && n_acc == n0, "R9 no follow-on run", 32'(n_acc - n0), 32'd0);
      chk(nx_ip == ip0, "R5 outputs held", nx_ip, ip0);
    end

    run_switch("fast trap", 32'h80, 32'h00, 0, 1'b1, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule